// File: doc/BRIEF.md
# Timer and External Interrupt Control Register

This block is an 8-bit control and status register for a small microcontroller peripheral bus. It holds the run-enable bits of two timers, latches their overflow events as interrupt request flags, and turns two active-low external interrupt pins into request flags. Each external pin has a mode bit that picks how its flag behaves. In edge mode the flag latches on a falling edge and is cleared when the interrupt controller acknowledges the vector. In level mode the flag follows the inverted pin level.

Software reaches the register in two ways. A byte access at the register address moves all eight bits at once. A single-bit access, at bit address base+n, changes only bit n and leaves the other seven bits as they are. Every request flag is a small two-state machine with the states FLG_IDLE and FLG_PEND. The transitions are:
- IDLE to PEND on a hardware set or a software write of 1.
- PEND to IDLE on an acknowledge or a software write of 0.
- In level mode, the state is reloaded every cycle from the pin unless software writes the flag in that cycle.

A hardware set always wins over a clear in the same cycle.

Top module: `tmr_xint_ctrl`

## Requirements
- R1: After reset the register reads 0x00. Bit 7 is the timer-1 flag, bit 6 timer-1 run, bit 5 timer-0 flag, bit 4 timer-0 run, bit 3 external-1 flag, bit 2 external-1 mode, bit 1 external-0 flag, bit 0 external-0 mode.
- R2: A byte write at address 0x88 loads all eight bits on the next clock edge. A byte write at any other address changes nothing.
- R3: A bit write at bit address 0x88+n (n = 0..7) changes only bit n, including in a cycle where hardware updates another flag. Bit writes outside 0x88..0x8F change nothing. `bit_rdata` returns bit n of the current register for the bit address presented.
- R4: A one-cycle overflow pulse sets the matching timer flag at the next edge. The matching acknowledge strobe clears it at the next edge.
- R5: A hardware set in the same cycle as an acknowledge, or as a software write of 0 to that flag, leaves the flag at 1.
- R6: The run bits are plain read/write bits, driven straight to `run0` and `run1`, and change only through writes.
- R7: With its mode bit at 1, an external flag is set on a falling edge of the pin after a two-flop synchronizer. It goes high on the third clock edge after the pin falls. It is not set by a rising edge or by a pin held low, and the external acknowledge clears it.
- R8: With its mode bit at 0, an external flag follows the inverted pin with a three-edge delay and ignores acknowledge. A software write to the flag shows for one cycle and is then replaced by the pin level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_we | input | 1 | Byte write strobe |
| byte_addr | input | 8 | Byte write address |
| byte_wdata | input | 8 | Byte write data |
| bit_we | input | 1 | Single-bit write strobe |
| bit_addr | input | 8 | Bit address for bit write and bit read |
| bit_wdata | input | 1 | Single-bit write value |
| rd_data | output | 8 | Current register contents |
| bit_rdata | output | 1 | Register bit selected by bit_addr |
| t0_ovf | input | 1 | Timer 0 overflow pulse |
| t1_ovf | input | 1 | Timer 1 overflow pulse |
| xint0_n | input | 1 | External interrupt 0 pin, active low |
| xint1_n | input | 1 | External interrupt 1 pin, active low |
| ack_t0 | input | 1 | Vector acknowledge, timer 0 |
| ack_t1 | input | 1 | Vector acknowledge, timer 1 |
| ack_x0 | input | 1 | Vector acknowledge, external 0 |
| ack_x1 | input | 1 | Vector acknowledge, external 1 |
| run0 | output | 1 | Timer 0 run enable |
| run1 | output | 1 | Timer 1 run enable |
| flag_t0 | output | 1 | Timer 0 request flag |
| flag_t1 | output | 1 | Timer 1 request flag |
| flag_x0 | output | 1 | External 0 request flag |
| flag_x1 | output | 1 | External 1 request flag |

## Verification
The properties assume that byte and bit writes never arrive in the same cycle. They also assume the external pins sit high during reset, so the synchronizer's reset value of 1 agrees with the pin history the properties look back on. The pin-history properties wait a few cycles after reset before they apply, because they compare a flag with pin samples up to four edges old. The directed stimulus holds the pins high through reset, issues at most one kind of write per cycle, and changes the pins only at falling clock edges.

// File: rtl/tmr_xint_pkg.sv
`timescale 1ns/1ps
package tmr_xint_pkg;

    localparam int CTRL_W = 8;
    localparam int N_CH   = 2;

    // Bit layout of the control register (decoded by neighbours, so fixed)
    localparam int POS_X0_MODE = 0;
    localparam int POS_X0_FLAG = 1;
    localparam int POS_X1_MODE = 2;
    localparam int POS_X1_FLAG = 3;
    localparam int POS_T0_RUN  = 4;
    localparam int POS_T0_FLAG = 5;
    localparam int POS_T1_RUN  = 6;
    localparam int POS_T1_FLAG = 7;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_state_e;

    function automatic int tflag_pos(input int ch);
        return (ch == 0) ? POS_T0_FLAG : POS_T1_FLAG;
    endfunction

    function automatic int trun_pos(input int ch);
        return (ch == 0) ? POS_T0_RUN : POS_T1_RUN;
    endfunction

    function automatic int xflag_pos(input int ch);
        return (ch == 0) ? POS_X0_FLAG : POS_X1_FLAG;
    endfunction

    function automatic int xmode_pos(input int ch);
        return (ch == 0) ? POS_X0_MODE : POS_X1_MODE;
    endfunction

endpackage

// File: rtl/ctrl_wr_decode.sv
`timescale 1ns/1ps
module ctrl_wr_decode #(
    parameter int          W         = 8,
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  BASE_ADDR = 8'h88
) (
    input  logic              byte_we,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [W-1:0]      byte_wdata,
    input  logic              bit_we,
    input  logic [ADDR_W-1:0] bit_addr,
    input  logic              bit_wdata,
    output logic [W-1:0]      wr_mask,
    output logic [W-1:0]      wr_data
);
    localparam int IDX_W = $clog2(W);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

    logic             byte_hit;
    logic             bit_hit;
    logic [IDX_W-1:0] bit_idx;

    assign byte_hit = byte_we && (byte_addr == BASE);
    assign bit_hit  = bit_we && (bit_addr[ADDR_W-1:IDX_W] == BASE[ADDR_W-1:IDX_W]);
    assign bit_idx  = bit_addr[IDX_W-1:0];

    always_comb begin
        wr_mask = '0;
        wr_data = '0;
        if (byte_hit) begin
            wr_mask = '1;
            wr_data = byte_wdata;
        end else if (bit_hit) begin
            wr_mask[bit_idx] = 1'b1;
            wr_data[bit_idx] = bit_wdata;
        end
    end
endmodule

// File: rtl/xint_sync.sv
`timescale 1ns/1ps
module xint_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic level_req,
    output logic fall_ev
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_n};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign level_req = ~sync_q[STAGES-1];
    assign fall_ev   = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/irq_flag_cell.sv
`timescale 1ns/1ps
module irq_flag_cell
    import tmr_xint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_mode,
    input  logic level_req,
    input  logic set_ev,
    input  logic ack,
    input  logic sw_we,
    input  logic sw_val,
    output logic flag
);
    flag_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (level_mode) begin
            if (sw_we) state_d = sw_val    ? FLG_PEND : FLG_IDLE;
            else       state_d = level_req ? FLG_PEND : FLG_IDLE;
        end else begin
            unique case (state_q)
                FLG_IDLE: begin
                    if (set_ev || (sw_we && sw_val)) state_d = FLG_PEND;
                end
                FLG_PEND: begin
                    if (set_ev)     state_d = FLG_PEND;
                    else if (sw_we) state_d = sw_val ? FLG_PEND : FLG_IDLE;
                    else if (ack)   state_d = FLG_IDLE;
                end
            endcase
        end
    end

    // Output
    always_comb begin
        flag = (state_q == FLG_PEND);
    end
endmodule

// File: rtl/tmr_xint_ctrl.sv
`timescale 1ns/1ps
module tmr_xint_ctrl
    import tmr_xint_pkg::*;
#(
    parameter int         ADDR_W      = 8,
    parameter logic [7:0] BASE_ADDR   = 8'h88,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_we,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [7:0]        byte_wdata,
    input  logic              bit_we,
    input  logic [ADDR_W-1:0] bit_addr,
    input  logic              bit_wdata,
    output logic [7:0]        rd_data,
    output logic              bit_rdata,
    input  logic              t0_ovf,
    input  logic              t1_ovf,
    input  logic              xint0_n,
    input  logic              xint1_n,
    input  logic              ack_t0,
    input  logic              ack_t1,
    input  logic              ack_x0,
    input  logic              ack_x1,
    output logic              run0,
    output logic              run1,
    output logic              flag_t0,
    output logic              flag_t1,
    output logic              flag_x0,
    output logic              flag_x1
);
    localparam int IDX_W = $clog2(CTRL_W);

    logic [CTRL_W-1:0] wr_mask, wr_data;
    logic [N_CH-1:0]   ovf_v, pin_v, ackt_v, ackx_v;
    logic [N_CH-1:0]   run_q, mode_q, tflag_v, xflag_v;
    logic [N_CH-1:0]   lvl_v, fall_v;
    logic [CTRL_W-1:0] img;

    assign ovf_v  = {t1_ovf, t0_ovf};
    assign pin_v  = {xint1_n, xint0_n};
    assign ackt_v = {ack_t1, ack_t0};
    assign ackx_v = {ack_x1, ack_x0};

    ctrl_wr_decode #(
        .W(CTRL_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
    ) u_dec (
        .byte_we(byte_we), .byte_addr(byte_addr), .byte_wdata(byte_wdata),
        .bit_we(bit_we), .bit_addr(bit_addr), .bit_wdata(bit_wdata),
        .wr_mask(wr_mask), .wr_data(wr_data)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        localparam int TF = tflag_pos(ch);
        localparam int TR = trun_pos(ch);
        localparam int XF = xflag_pos(ch);
        localparam int XM = xmode_pos(ch);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                run_q[ch]  <= 1'b0;
                mode_q[ch] <= 1'b0;
            end else begin
                if (wr_mask[TR]) run_q[ch]  <= wr_data[TR];
                if (wr_mask[XM]) mode_q[ch] <= wr_data[XM];
            end
        end

        irq_flag_cell u_tflag (
            .clk(clk), .rst_n(rst_n),
            .level_mode(1'b0), .level_req(1'b0),
            .set_ev(ovf_v[ch]), .ack(ackt_v[ch]),
            .sw_we(wr_mask[TF]), .sw_val(wr_data[TF]),
            .flag(tflag_v[ch])
        );

        xint_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .pin_n(pin_v[ch]),
            .level_req(lvl_v[ch]), .fall_ev(fall_v[ch])
        );

        irq_flag_cell u_xflag (
            .clk(clk), .rst_n(rst_n),
            .level_mode(~mode_q[ch]), .level_req(lvl_v[ch]),
            .set_ev(fall_v[ch]), .ack(ackx_v[ch]),
            .sw_we(wr_mask[XF]), .sw_val(wr_data[XF]),
            .flag(xflag_v[ch])
        );
    end

    always_comb begin
        img = '0;
        for (int ch = 0; ch < N_CH; ch++) begin
            img[tflag_pos(ch)] = tflag_v[ch];
            img[trun_pos(ch)]  = run_q[ch];
            img[xflag_pos(ch)] = xflag_v[ch];
            img[xmode_pos(ch)] = mode_q[ch];
        end
    end

    assign rd_data   = img;
    assign bit_rdata = img[bit_addr[IDX_W-1:0]];
    assign run0      = run_q[0];
    assign run1      = run_q[1];
    assign flag_t0   = tflag_v[0];
    assign flag_t1   = tflag_v[1];
    assign flag_x0   = xflag_v[0];
    assign flag_x1   = xflag_v[1];
endmodule

// File: rtl/tmr_xint_ctrl_chk.sv
`timescale 1ns/1ps
module tmr_xint_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_we,
    input logic       bit_we,
    input logic [7:0] rd_data,
    input logic       t0_ovf,
    input logic       t1_ovf,
    input logic       xint0_n,
    input logic       ack_t0,
    input logic       run0,
    input logic       run1,
    input logic       flag_t0,
    input logic       flag_t1,
    input logic       flag_x0
);
    logic [2:0] cyc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cyc_q <= '0;
        else if (cyc_q != 3'd7)  cyc_q <= cyc_q + 3'd1;
    end

    logic no_wr;
    assign no_wr = !byte_we && !bit_we;

    a_r1_reset_zero: assert property (@(posedge clk) !rst_n |-> rd_data == 8'h00);

    a_r4_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (t0_ovf |=> flag_t0));

    a_r5_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_ovf |=> flag_t1));

    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_t0 && !t0_ovf && no_wr |=> !flag_t0));

    a_r6_run_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (no_wr |=> $stable(run0) && $stable(run1)));

    a_r8_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc_q >= 3'd4) && !rd_data[0] && no_wr |=> flag_x0 == !$past(xint0_n, 3)));

    a_r7_edge_needs_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc_q >= 3'd6) && $rose(flag_x0) && $past(rd_data[0]) && $past(no_wr)
         |-> !$past(xint0_n, 3) && $past(xint0_n, 4)));
endmodule

bind tmr_xint_ctrl tmr_xint_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .byte_we(byte_we), .bit_we(bit_we),
    .rd_data(rd_data), .t0_ovf(t0_ovf), .t1_ovf(t1_ovf), .xint0_n(xint0_n),
    .ack_t0(ack_t0), .run0(run0), .run1(run1), .flag_t0(flag_t0),
    .flag_t1(flag_t1), .flag_x0(flag_x0)
);

// File: tb/tmr_xint_ctrl_bench.sv
`timescale 1ns/1ps
module tmr_xint_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_we = 1'b0;
    logic [7:0] byte_addr = 8'h00;
    logic [7:0] byte_wdata = 8'h00;
    logic       bit_we = 1'b0;
    logic [7:0] bit_addr = 8'h00;
    logic       bit_wdata = 1'b0;
    logic [7:0] rd_data;
    logic       bit_rdata;
    logic       t0_ovf = 1'b0, t1_ovf = 1'b0;
    logic       xint0_n = 1'b1, xint1_n = 1'b1;
    logic       ack_t0 = 1'b0, ack_t1 = 1'b0, ack_x0 = 1'b0, ack_x1 = 1'b0;
    logic       run0, run1, flag_t0, flag_t1, flag_x0, flag_x1;

    int vectors = 0;
    int miscompares = 0;

    always #2.5 clk = ~clk;

    tmr_xint_ctrl u_tmr_xint_ctrl (
        .clk(clk), .rst_n(rst_n),
        .byte_we(byte_we), .byte_addr(byte_addr), .byte_wdata(byte_wdata),
        .bit_we(bit_we), .bit_addr(bit_addr), .bit_wdata(bit_wdata),
        .rd_data(rd_data), .bit_rdata(bit_rdata),
        .t0_ovf(t0_ovf), .t1_ovf(t1_ovf), .xint0_n(xint0_n), .xint1_n(xint1_n),
        .ack_t0(ack_t0), .ack_t1(ack_t1), .ack_x0(ack_x0), .ack_x1(ack_x1),
        .run0(run0), .run1(run1), .flag_t0(flag_t0), .flag_t1(flag_t1),
        .flag_x0(flag_x0), .flag_x1(flag_x1)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
        byte_we = 1'b1; byte_addr = a; byte_wdata = d;
        step(1);
        byte_we = 1'b0;
    endtask

    task automatic wr_bit(input logic [7:0] a, input logic v);
        bit_we = 1'b1; bit_addr = a; bit_wdata = v;
        step(1);
        bit_we = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset image", rd_data, 8'h00);
        check("R1 reset flags", {4'h0, flag_t1, flag_t0, flag_x1, flag_x0}, 8'h00);
    endtask

    task automatic t_byte_rw();
        wr_byte(8'h88, 8'h50);
        check("R2 byte write", rd_data, 8'h50);
        check("R6 run outputs", {6'h0, run1, run0}, 8'h03);
        wr_byte(8'h89, 8'hFF);
        check("R2 other address ignored", rd_data, 8'h50);
        wr_byte(8'h88, 8'h00);
        check("R6 run cleared", {6'h0, run1, run0}, 8'h00);
    endtask

    task automatic t_bit_rw();
        wr_bit(8'h8C, 1'b1);
        check("R3 bit set run0", rd_data, 8'h10);
        bit_addr = 8'h8C;
        step(0);
        check("R3 bit read", {7'h0, bit_rdata}, 8'h01);
        wr_bit(8'h8E, 1'b1);
        check("R3 bit keeps others", rd_data, 8'h50);
        wr_bit(8'h90, 1'b1);
        check("R3 out of range ignored", rd_data, 8'h50);
        wr_bit(8'h8C, 1'b0);
        check("R3 bit clear", rd_data, 8'h40);
        wr_byte(8'h88, 8'h00);
    endtask

    task automatic t_timer_flag();
        t0_ovf = 1'b1; step(1); t0_ovf = 1'b0;
        check("R4 timer0 set", {7'h0, flag_t0}, 8'h01);
        check("R4 timer0 in image", rd_data, 8'h20);
        ack_t0 = 1'b1; step(1); ack_t0 = 1'b0;
        check("R4 timer0 ack clear", {7'h0, flag_t0}, 8'h00);
        t1_ovf = 1'b1; step(1); t1_ovf = 1'b0;
        check("R4 timer1 set", rd_data, 8'h80);
        ack_t1 = 1'b1; step(1); ack_t1 = 1'b0;
        check("R4 timer1 ack clear", rd_data, 8'h00);
    endtask

    task automatic t_set_wins();
        t0_ovf = 1'b1; ack_t0 = 1'b1; step(1); t0_ovf = 1'b0; ack_t0 = 1'b0;
        check("R5 set beats ack", {7'h0, flag_t0}, 8'h01);
        ack_t0 = 1'b1; step(1); ack_t0 = 1'b0;
        t1_ovf = 1'b1;
        wr_bit(8'h8F, 1'b0);
        t1_ovf = 1'b0;
        check("R5 set beats sw clear", rd_data, 8'h80);
        ack_t1 = 1'b1; step(1); ack_t1 = 1'b0;
        check("R5 cleanup", rd_data, 8'h00);
    endtask

    task automatic t_edge();
        wr_bit(8'h88, 1'b1);
        xint0_n = 1'b0;
        step(2);
        check("R7 ext0 not yet", {7'h0, flag_x0}, 8'h00);
        step(1);
        check("R7 ext0 falling edge", {7'h0, flag_x0}, 8'h01);
        step(3);
        ack_x0 = 1'b1; step(1); ack_x0 = 1'b0;
        check("R7 ext0 ack clear", {7'h0, flag_x0}, 8'h00);
        step(4);
        check("R7 steady low no set", {7'h0, flag_x0}, 8'h00);
        xint0_n = 1'b1;
        step(5);
        check("R7 rising no set", {7'h0, flag_x0}, 8'h00);
        wr_bit(8'h8A, 1'b1);
        xint1_n = 1'b0;
        step(3);
        check("R7 ext1 falling edge", rd_data, 8'h0D);
        ack_x1 = 1'b1; step(1); ack_x1 = 1'b0;
        xint1_n = 1'b1;
        check("R7 ext1 ack clear", {7'h0, flag_x1}, 8'h00);
        step(4);
        wr_byte(8'h88, 8'h00);
    endtask

    task automatic t_level();
        step(4);
        xint0_n = 1'b0;
        step(3);
        check("R8 level follows low", {7'h0, flag_x0}, 8'h01);
        ack_x0 = 1'b1; step(1); ack_x0 = 1'b0;
        check("R8 ack ignored", {7'h0, flag_x0}, 8'h01);
        xint0_n = 1'b1;
        step(3);
        check("R8 level follows high", {7'h0, flag_x0}, 8'h00);
        wr_bit(8'h89, 1'b1);
        check("R8 sw write visible", {7'h0, flag_x0}, 8'h01);
        step(1);
        check("R8 pin overwrites sw", {7'h0, flag_x0}, 8'h00);
    endtask

    task automatic t_rmw();
        t1_ovf = 1'b1;
        wr_bit(8'h8C, 1'b1);
        t1_ovf = 1'b0;
        check("R3 bit write beside hw set", rd_data, 8'h90);
        ack_t1 = 1'b1; step(1); ack_t1 = 1'b0;
        wr_byte(8'h88, 8'h00);
        check("R3 rmw cleanup", rd_data, 8'h00);
    endtask

    initial begin
        step(3);
        t_reset();
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_byte_rw();
        t_bit_rw();
        t_timer_flag();
        t_set_wins();
        t_edge();
        t_level();
        t_rmw();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #100000;
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule